// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the target side of an I2C port. It watches the sampled SCL and SDA lines for START and STOP, shifts in each address byte and compares it with a programmable 7-bit station address. It can also answer the general call address 00h. When it is addressed it either takes in data bytes from the controller and acknowledges them, or it shifts out bytes that the host supplies.

Every event ends with an interrupt flag and an 8-bit status code for the host. After each completed byte the block holds SCL low until the host clears the flag. A respond-enable input controls whether the block answers at all. It also marks whether the local controller has just lost arbitration, so that the host can tell a takeover entry from a normal one.

The bus pins are open-drain. The block only asks to pull SDA or SCL low, and the surrounding logic forms the wired-AND line and feeds the resolved levels back into `scl_i` and `sda_i`. These inputs are taken as already synchronous to `clk`.

Top module: `i2c_slave_addr_rec`

## Requirements
- R1: When an address byte matches `own_addr_i[7:1]` and its R/W bit is 0 while `resp_en_i`=1, the block pulls SDA low in the ninth bit. It then raises `irq_o` with status 60h and holds SCL low (`scl_hold_o`=1) until a one-cycle `irq_clr_i` pulse.
- R2: A match with the R/W bit at 1 gives status A8h. The `irq_clr_i` pulse that ends it loads `tx_data_i`, and the block then shifts that byte out MSB first, one bit for each SCL low phase.
- R3: The address byte 00h (general call) is acknowledged with status 70h only while `own_addr_i[0]`=1. While that bit is 0 it gets no ACK and no interrupt. A byte of 01h is never taken as a general call.
- R4: Any other address byte gets no ACK and no interrupt. The block then stays quiet until the next START.
- R5: While `resp_en_i`=0, neither the station address nor the general call is acknowledged and no interrupt is raised.
- R6: Once the block is addressed for write, each data byte is acknowledged while `resp_en_i`=1. The byte appears on `rx_data_o` and status 80h is posted.
- R7: If `resp_en_i` falls during a write transfer, the next data byte is not acknowledged (SDA left high) and status 88h is posted. The block then leaves the addressed state and ignores further bytes until a new START.
- R8: After a one-cycle pulse on `arb_lost_i` (the pulse may coincide with the address decision), the next match reports 68h for write, 78h for a general call and B0h for read, in place of 60h, 70h and A8h.
- R9: A STOP or a repeated START while the block is addressed posts status A0h with `irq_o`=1 and `scl_hold_o`=0. After a STOP the block is not addressed. After a repeated START it takes the next address byte.
- R10: In transmit mode, a controller ACK after a byte posts B8h. A controller NACK posts C0h, releases SDA and leaves the addressed state.
- R11: Setting `resp_en_i` back to 1 restores recognition from the next address byte.
- R12: Out of reset, `status_o`=F8h, `irq_o`=0, and both `sda_low_o` and `scl_hold_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| own_addr_i | input | 8 | [7:1] station address, [0] general-call enable |
| resp_en_i | input | 1 | Respond enable (acknowledge control) |
| arb_lost_i | input | 1 | One-cycle pulse: local controller lost arbitration |
| irq_clr_i | input | 1 | One-cycle pulse: host clears the interrupt flag |
| tx_data_i | input | 8 | Byte to transmit, loaded on `irq_clr_i` in transmit mode |
| sda_low_o | output | 1 | Request to pull SDA low |
| scl_hold_o | output | 1 | Request to hold SCL low |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code of the last event |
| rx_data_o | output | 8 | Last received data byte |

## Verification
An arbitration-lost pulse and the address decision can land in the same clock: the decision is taken on the SCL fall after the eighth address bit. The bench forces this by raising `arb_lost_i` for one cycle at exactly the clock where the controller model drops SCL after bit 0. It judges the result by the status code: 68h proves the pulse was merged into the decision, and 60h would show it was lost. The address sweep covers all 256 address bytes with the general call enabled, against an expectation computed from the station address.

// File: rtl/i2c_sar_pkg.sv
package i2c_sar_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_RX, PH_TX} phase_e;

    localparam logic [BYTE_W-1:0] ST_NOINFO  = 8'hF8;
    localparam logic [BYTE_W-1:0] ST_OWN_W   = 8'h60;
    localparam logic [BYTE_W-1:0] ST_LOST_W  = 8'h68;
    localparam logic [BYTE_W-1:0] ST_GC      = 8'h70;
    localparam logic [BYTE_W-1:0] ST_LOST_GC = 8'h78;
    localparam logic [BYTE_W-1:0] ST_RX_ACK  = 8'h80;
    localparam logic [BYTE_W-1:0] ST_RX_NACK = 8'h88;
    localparam logic [BYTE_W-1:0] ST_END     = 8'hA0;
    localparam logic [BYTE_W-1:0] ST_OWN_R   = 8'hA8;
    localparam logic [BYTE_W-1:0] ST_LOST_R  = 8'hB0;
    localparam logic [BYTE_W-1:0] ST_TX_ACK  = 8'hB8;
    localparam logic [BYTE_W-1:0] ST_TX_NACK = 8'hC0;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] rxd;
        logic [BYTE_W-1:0] status;
        logic              sda_low;
        logic              hold;
        logic              irq;
        logic              rw;
        logic              gc;
        logic              mlost;
        logic              lost;
        logic              ackf;
    } core_t;

    localparam core_t CORE_RST = '{ph: PH_IDLE, cnt: '0, shreg: '0, rxd: '0,
                                   status: ST_NOINFO, sda_low: 1'b0, hold: 1'b0,
                                   irq: 1'b0, rw: 1'b0, gc: 1'b0, mlost: 1'b0,
                                   lost: 1'b0, ackf: 1'b0};
endpackage

// File: rtl/sar_bus_edges.sv
module sar_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t d, q;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl: 1'b1, sda: 1'b1};
        else        q <= d;
    end

    assign scl_rise = scl_i & ~q.scl;
    assign scl_fall = ~scl_i & q.scl;
    assign start_ev = q.scl & scl_i & q.sda & ~sda_i;
    assign stop_ev  = q.scl & scl_i & ~q.sda & sda_i;
endmodule

// File: rtl/sar_addr_match.sv
module sar_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0] addr_byte,
    input  logic [ADDR_W:0] own_addr,
    input  logic            resp_en,
    output logic            hit,
    output logic            hit_gc
);
    logic own_hit;
    logic gc_hit;

    assign own_hit = (addr_byte[ADDR_W:1] == own_addr[ADDR_W:1]) && (addr_byte[ADDR_W:1] != '0);
    assign gc_hit  = (addr_byte == '0) && own_addr[0];
    assign hit     = resp_en & (own_hit | gc_hit);
    assign hit_gc  = gc_hit;
endmodule

// File: rtl/sar_core.sv
module sar_core
    import i2c_sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              hit,
    input  logic              hit_gc,
    input  logic              resp_en,
    input  logic              arb_lost,
    input  logic              irq_clr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] shreg,
    output logic              sda_low,
    output logic              hold,
    output logic              irq,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rx_data
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    core_t d, q;
    logic  addressed;
    logic  lost_now;

    assign addressed = (q.ph == PH_RX) || (q.ph == PH_TX);
    assign lost_now  = q.lost | arb_lost;

    always_comb begin
        d = q;
        if (arb_lost) d.lost = 1'b1;
        if (irq_clr) begin
            d.irq  = 1'b0;
            d.hold = 1'b0;
            if (q.ph == PH_TX && q.hold) begin
                d.shreg   = tx_data;
                d.sda_low = ~tx_data[BYTE_W-1];
            end
        end
        if (start_ev) begin
            if (addressed) begin
                d.irq    = 1'b1;
                d.hold   = 1'b0;
                d.status = ST_END;
            end
            d.ph      = PH_ADDR;
            d.cnt     = '0;
            d.sda_low = 1'b0;
        end else if (stop_ev) begin
            if (addressed) begin
                d.irq    = 1'b1;
                d.hold   = 1'b0;
                d.status = ST_END;
            end
            d.ph      = PH_IDLE;
            d.cnt     = '0;
            d.sda_low = 1'b0;
            d.lost    = 1'b0;
        end else begin
            case (q.ph)
                PH_IDLE: ;
                PH_ADDR, PH_RX: begin
                    if (scl_rise) begin
                        if (q.cnt < LAST_BIT) d.shreg = {q.shreg[BYTE_W-2:0], sda_i};
                        if (q.cnt < ACK_BIT)  d.cnt   = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        if (q.ph == PH_ADDR) begin
                            if (hit) begin
                                d.sda_low = 1'b1;
                                d.rw      = q.shreg[0];
                                d.gc      = hit_gc;
                                d.mlost   = lost_now;
                            end else begin
                                d.ph  = PH_IDLE;
                                d.cnt = '0;
                            end
                            d.lost = 1'b0;
                        end else begin
                            d.rxd     = q.shreg;
                            d.ackf    = resp_en;
                            d.sda_low = resp_en;
                        end
                    end else if (scl_fall && q.cnt == ACK_BIT) begin
                        d.sda_low = 1'b0;
                        d.cnt     = '0;
                        d.irq     = 1'b1;
                        d.hold    = 1'b1;
                        if (q.ph == PH_ADDR) begin
                            d.ph = q.rw ? PH_TX : PH_RX;
                            if (q.rw)      d.status = q.mlost ? ST_LOST_R  : ST_OWN_R;
                            else if (q.gc) d.status = q.mlost ? ST_LOST_GC : ST_GC;
                            else           d.status = q.mlost ? ST_LOST_W  : ST_OWN_W;
                        end else begin
                            d.status = q.ackf ? ST_RX_ACK : ST_RX_NACK;
                            if (!q.ackf) d.ph = PH_IDLE;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise) begin
                        if (q.cnt == LAST_BIT) d.ackf = ~sda_i;
                        if (q.cnt < ACK_BIT)   d.cnt  = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt != '0 && q.cnt < LAST_BIT) begin
                            d.shreg   = {q.shreg[BYTE_W-2:0], 1'b1};
                            d.sda_low = ~q.shreg[BYTE_W-2];
                        end else if (q.cnt == LAST_BIT) begin
                            d.sda_low = 1'b0;
                        end else if (q.cnt == ACK_BIT) begin
                            d.cnt    = '0;
                            d.irq    = 1'b1;
                            d.hold   = 1'b1;
                            d.status = q.ackf ? ST_TX_ACK : ST_TX_NACK;
                            if (!q.ackf) d.ph = PH_IDLE;
                        end
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CORE_RST;
        else        q <= d;
    end

    assign shreg   = q.shreg;
    assign sda_low = q.sda_low;
    assign hold    = q.hold;
    assign irq     = q.irq;
    assign status  = q.status;
    assign rx_data = q.rxd;
endmodule

// File: rtl/i2c_slave_addr_rec.sv
module i2c_slave_addr_rec
    import i2c_sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] own_addr_i,
    input  logic              resp_en_i,
    input  logic              arb_lost_i,
    input  logic              irq_clr_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              sda_low_o,
    output logic              scl_hold_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] rx_data_o
);
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic hit, hit_gc;
    logic [BYTE_W-1:0] shreg;

    sar_bus_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    sar_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .addr_byte(shreg), .own_addr(own_addr_i), .resp_en(resp_en_i),
        .hit(hit), .hit_gc(hit_gc)
    );

    sar_core u_core (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev),
        .hit(hit), .hit_gc(hit_gc), .resp_en(resp_en_i),
        .arb_lost(arb_lost_i), .irq_clr(irq_clr_i), .tx_data(tx_data_i),
        .shreg(shreg), .sda_low(sda_low_o), .hold(scl_hold_o),
        .irq(irq_o), .status(status_o), .rx_data(rx_data_o)
    );
endmodule

// File: rtl/sar_checker.sv
module sar_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic [7:0] own_addr_i,
    input logic       irq_clr_i,
    input logic       sda_low_o,
    input logic       scl_hold_o,
    input logic       irq_o,
    input logic [7:0] status_o
);
    // R1: the flag stays up until the host clears it
    a_r1_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);

    // R1: SCL is only held while an interrupt is pending
    a_r1_hold_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold_o |-> irq_o);

    // R9: an end event never stretches the clock
    a_r9_end_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && status_o == 8'hA0) |-> !scl_hold_o);

    // R3: general-call status only with the enable bit set
    a_r3_gc_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && (status_o == 8'h70 || status_o == 8'h78)) |-> own_addr_i[0]);

    // R10: SDA drive changes only while SCL was low
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_o) |-> !$past(scl_i));
endmodule

bind i2c_slave_addr_rec sar_checker u_sar_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .own_addr_i(own_addr_i),
    .irq_clr_i(irq_clr_i), .sda_low_o(sda_low_o), .scl_hold_o(scl_hold_o),
    .irq_o(irq_o), .status_o(status_o)
);

// File: tb/sim_i2c_slave_addr_rec.sv
`timescale 1ns/1ps
module sim_i2c_slave_addr_rec;
    localparam logic [6:0] OWN = 7'h5A;
    localparam logic [7:0] OWN_W = {OWN, 1'b0};
    localparam logic [7:0] OWN_R = {OWN, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] own_addr = {OWN, 1'b1};
    logic resp_en = 1'b1, arb_lost = 1'b0, irq_clr = 1'b0;
    logic [7:0] tx_data = 8'hFF;
    logic sda_low, scl_hold, irq;
    logic [7:0] status, rx_data;
    logic scl_bus, sda_bus;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign scl_bus = scl_m & ~scl_hold;
    assign sda_bus = sda_m & ~sda_low;

    i2c_slave_addr_rec u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .own_addr_i(own_addr), .resp_en_i(resp_en), .arb_lost_i(arb_lost),
        .irq_clr_i(irq_clr), .tx_data_i(tx_data), .sda_low_o(sda_low),
        .scl_hold_o(scl_hold), .irq_o(irq), .status_o(status), .rx_data_o(rx_data)
    );

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic q4();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q4();
        scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
        q4();
        sda_m = 1'b0; q4();
        scl_m = 1'b0; q4();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q4();
        scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
        q4();
        sda_m = 1'b1; q4();
    endtask

    task automatic clk_bit(input logic b, input logic pulse, output logic s);
        sda_m = b; q4();
        scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
        q4();
        s = sda_bus;
        scl_m = 1'b0;
        if (pulse) begin
            arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
            repeat (3) @(negedge clk);
        end else q4();
    endtask

    task automatic put_byte(input logic [7:0] v, input logic pulse, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], pulse && i == 0, s);
        clk_bit(1'b1, 1'b0, s);
        acked = ~s;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, s);
            v[i] = s;
        end
        clk_bit(~mack, 1'b0, s);
    endtask

    task automatic host_clear(input logic [7:0] txv);
        tx_data = txv;
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        q4();
    endtask

    // Address only, check ack and status, then end with STOP
    task automatic addr_probe(string tag, input logic [7:0] a, input logic exp_ack,
                              input logic [7:0] exp_st);
        logic ack;
        bus_start();
        put_byte(a, 1'b0, ack);
        chk({tag, " ack"}, {7'd0, ack}, {7'd0, exp_ack});
        if (exp_ack) begin
            chk({tag, " status"}, status, exp_st);
            host_clear(8'hFF);
            bus_stop();
            chk({tag, " stop A0"}, {irq, status}, {1'b1, 8'hA0});
            host_clear(8'hFF);
        end else begin
            chk({tag, " no irq"}, {7'd0, irq}, 8'd0);
            bus_stop();
            chk({tag, " quiet after stop"}, {7'd0, irq}, 8'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        q4();
        // R12 reset state
        chk("R12 status", status, 8'hF8);
        chk("R12 outputs", {5'd0, irq, sda_low, scl_hold}, 8'd0);

        // R1 R2 R3 R4: sweep every address byte, general call enabled
        for (int b = 0; b < 256; b++) begin
            logic [7:0] a = 8'(b);
            logic m = (a[7:1] == OWN) || (a == 8'h00);
            logic [7:0] es = (a == 8'h00) ? 8'h70 : (a[0] ? 8'hA8 : 8'h60);
            addr_probe("R4 sweep", a, m, es);
        end

        // R1 clock stretching
        bus_start();
        put_byte(OWN_W, 1'b0, ack);
        chk("R1 status", status, 8'h60);
        repeat (30) @(negedge clk);
        chk("R1 hold while pending", {6'd0, scl_hold, irq}, 8'd3);
        host_clear(8'hFF);
        chk("R1 released after clear", {7'd0, scl_hold}, 8'd0);

        // R6 data bytes acknowledged
        put_byte(8'h3C, 1'b0, ack);
        chk("R6 ack", {7'd0, ack}, 8'd1);
        chk("R6 data", rx_data, 8'h3C);
        chk("R6 status", status, 8'h80);
        host_clear(8'hFF);
        put_byte(8'hC3, 1'b0, ack);
        chk("R6 data2", rx_data, 8'hC3);
        host_clear(8'hFF);
        // R7 respond enable dropped mid transfer
        resp_en = 1'b0;
        put_byte(8'h55, 1'b0, ack);
        chk("R7 nack", {7'd0, ack}, 8'd0);
        chk("R7 status", status, 8'h88);
        host_clear(8'hFF);
        put_byte(8'hAA, 1'b0, ack);
        chk("R7 ignored byte", {6'd0, ack, irq}, 8'd0);
        bus_stop();
        chk("R7 not addressed at stop", {7'd0, irq}, 8'd0);
        // R5 no response while disabled
        addr_probe("R5 own write", OWN_W, 1'b0, 8'h00);
        addr_probe("R5 own read", OWN_R, 1'b0, 8'h00);
        addr_probe("R5 general call", 8'h00, 1'b0, 8'h00);
        // R11 recognition restored
        resp_en = 1'b1;
        addr_probe("R11 restored", OWN_W, 1'b1, 8'h60);

        // R3 general call disabled
        own_addr = {OWN, 1'b0};
        addr_probe("R3 gc off", 8'h00, 1'b0, 8'h00);
        addr_probe("R3 gc read", 8'h01, 1'b0, 8'h00);
        addr_probe("R3 own still", OWN_W, 1'b1, 8'h60);
        own_addr = {OWN, 1'b1};

        // R2 R10 transmit
        bus_start();
        put_byte(OWN_R, 1'b0, ack);
        chk("R2 status", status, 8'hA8);
        host_clear(8'hA5);
        get_byte(1'b1, v);
        chk("R2 byte out", v, 8'hA5);
        chk("R10 ack status", status, 8'hB8);
        host_clear(8'h3C);
        get_byte(1'b0, v);
        chk("R10 byte2 out", v, 8'h3C);
        chk("R10 nack status", status, 8'hC0);
        host_clear(8'h00);
        chk("R10 sda released", {7'd0, sda_low}, 8'd0);
        bus_stop();
        chk("R10 not addressed", {7'd0, irq}, 8'd0);

        // R8 arbitration lost entries
        @(negedge clk); arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
        addr_probe("R8 lost write", OWN_W, 1'b1, 8'h68);
        @(negedge clk); arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
        addr_probe("R8 lost gc", 8'h00, 1'b1, 8'h78);
        @(negedge clk); arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
        addr_probe("R8 lost read", OWN_R, 1'b1, 8'hB0);
        addr_probe("R8 flag consumed", OWN_W, 1'b1, 8'h60);
        // R8 pulse in the decision cycle
        bus_start();
        put_byte(OWN_W, 1'b1, ack);
        chk("R8 same-cycle status", status, 8'h68);
        host_clear(8'hFF);
        bus_stop();
        host_clear(8'hFF);

        // R9 repeated START while addressed
        bus_start();
        put_byte(OWN_W, 1'b0, ack);
        host_clear(8'hFF);
        put_byte(8'h11, 1'b0, ack);
        host_clear(8'hFF);
        bus_start();
        chk("R9 restart status", status, 8'hA0);
        chk("R9 restart no hold", {6'd0, irq, scl_hold}, 8'd2);
        host_clear(8'hFF);
        put_byte(OWN_W, 1'b0, ack);
        chk("R9 readdressed", status, 8'h60);
        host_clear(8'hFF);
        bus_stop();
        chk("R9 stop status", {irq, status}, {1'b1, 8'hA0});
        host_clear(8'hFF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule